// File: doc/BRIEF.md
# Two-Cache Write-Through Invalidate Coherence Controller

This block keeps the private caches of two processors consistent with one shared word-addressed memory. Each processor has its own direct-mapped cache controller. The two controllers share a single bus to memory. Each cached block is one memory word and has a valid bit and a tag. A read that finds a valid local copy completes from the cache and leaves the bus idle. A read miss fetches the word over the bus and fills the line.

Every processor write crosses the bus and goes straight to memory. The writer's cache line is updated in the same bus cycle, and the line is allocated if it was absent. The other controller watches the bus. On a write to a block it holds, it drops its copy. No cache ever holds data that memory lacks, so a line has no dirty state.

The bus serves one transaction at a time. When both controllers want it, processor 0 wins. A transaction is an address cycle followed by a response cycle. The memory itself sits outside the block.

Top module: `wit_coherent_pair`

## Requirements
- R1: A read of a valid local copy raises that port's done one cycle after the request is accepted. It returns the cached word and causes no bus transaction.
- R2: A read miss makes exactly one bus transaction. It returns the memory word, and done comes four cycles after the request is placed when the bus is idle. The line then becomes valid, so a repeat read hits.
- R3: A write always makes one bus transaction that stores the data in memory. It also leaves the writer holding the new value as a valid line, so a following read by the writer hits without a bus transaction.
- R4: A bus write by one port removes the other port's copy of that block. The other port's next read of it is a miss and returns the new value.
- R5: Both ports may hold valid copies of the same block at once. Each then reads it as a hit.
- R6: When both ports request the bus in the same cycle, port 0 is served first. For two writes to one block, memory ends with port 1's data.
- R7: The memory strobe mem_en is a single-cycle pulse. It is never high in two consecutive cycles, so transactions never overlap.
- R8: Caches are direct mapped, with the line index taken from the low address bits. A miss to another address with the same index evicts the old block, so a later read of the old block is a miss again.
- R9: After reset, no line is valid, both done outputs are low and mem_en is low.
- R10: A bus write to an address whose index matches a held line but whose tag differs leaves that line valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_req | input | 2 | Request per port, held until done |
| proc_we | input | 2 | 1 = write, 0 = read, per port |
| proc_addr | input | 2*ADDR_W | Word address, port 0 in the low slice |
| proc_wdata | input | 2*DATA_W | Write data per port |
| proc_done | output | 2 | One-cycle completion pulse per port |
| proc_rdata | output | 2*DATA_W | Read result per port, valid with done |
| mem_en | output | 1 | Memory access strobe (address cycle) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_en |

## Verification
A stale valid bit shows at the ports in two ways: a read returns an old value, or a read that should miss finishes in one cycle with no memory strobe. The bench therefore counts bus transactions and completion cycles around every access and checks the data returned. A missed invalidation shows on the very next read of the block by the other port. A lost write-through shows in memory right after the writing transaction. An arbitration fault shows in the order of done pulses when both ports request together.

// File: rtl/wit_pkg.sv
package wit_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_RESP = 2'd2
  } bus_phase_e;

  // fixed priority: port 0 wins whenever it asks
  function automatic logic pick_master(input logic [1:0] req);
    return req[0] ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/wit_bus_arbiter.sv
module wit_bus_arbiter
  import wit_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] bus_req,
  output bus_phase_e       phase,
  output logic             owner,
  output logic [NPORT-1:0] gnt_addr,
  output logic [NPORT-1:0] gnt_resp
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      owner <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (|bus_req) begin
          owner <= pick_master(bus_req);
          phase <= PH_ADDR;
        end
        PH_ADDR: phase <= PH_RESP;
        PH_RESP: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_gnt
    assign gnt_addr[g] = (phase == PH_ADDR) && (owner == 1'(g));
    assign gnt_resp[g] = (phase == PH_RESP) && (owner == 1'(g));
  end

  a_r6_port0_first: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && bus_req[0]) |=> (owner == 1'b0));
  a_r7_addr_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR) |=> (phase == PH_RESP));
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_addr | gnt_resp));

endmodule

// File: rtl/wit_cache.sv
module wit_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              gnt_addr,
  input  logic              gnt_resp,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              snoop_wr,
  input  logic [ADDR_W-1:0] snoop_addr
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic [SETS-1:0]   valid;
  logic [TAG_W-1:0]  tags  [SETS];
  logic [DATA_W-1:0] lines [SETS];
  logic              busy;

  // named events for the assertions
  logic             accept, local_hit_evt, snoop_kill, fill_evt, wr_alloc_evt;
  logic [IDX_W-1:0] req_idx, snoop_idx, op_idx;

  assign req_idx       = idx_of(addr);
  assign snoop_idx     = idx_of(snoop_addr);
  assign op_idx        = idx_of(bus_addr);
  assign accept        = req && !busy && !done;
  assign local_hit_evt = accept && !we && valid[req_idx] && (tags[req_idx] == tag_of(addr));
  assign snoop_kill    = snoop_wr && valid[snoop_idx] && (tags[snoop_idx] == tag_of(snoop_addr));
  assign wr_alloc_evt  = gnt_addr && bus_we;
  assign fill_evt      = gnt_resp && !bus_we;
  assign bus_req       = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      done <= 1'b0;
      if (local_hit_evt) begin
        rdata <= lines[req_idx];
        done  <= 1'b1;
      end else if (accept) begin
        busy      <= 1'b1;
        bus_we    <= we;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end
      if (snoop_kill) valid[snoop_idx] <= 1'b0;
      if (wr_alloc_evt) begin
        valid[op_idx] <= 1'b1;
        tags[op_idx]  <= tag_of(bus_addr);
        lines[op_idx] <= bus_wdata;
      end
      if (fill_evt) begin
        valid[op_idx] <= 1'b1;
        tags[op_idx]  <= tag_of(bus_addr);
        lines[op_idx] <= mem_rdata;
        rdata         <= mem_rdata;
      end
      if (gnt_resp) begin
        done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  a_r1_hit_stays_local: assert property (@(posedge clk) disable iff (!rst_n)
    local_hit_evt |=> (done && !bus_req));
  a_r2_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (valid[$past(op_idx)] && done));
  a_r3_write_allocates: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alloc_evt |=> valid[$past(op_idx)]);
  a_r4_snoop_drops: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_kill |=> !valid[$past(snoop_idx)]);

endmodule

// File: rtl/wit_coherent_pair.sv
module wit_coherent_pair
  import wit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SETS   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          proc_req,
  input  logic [1:0]          proc_we,
  input  logic [2*ADDR_W-1:0] proc_addr,
  input  logic [2*DATA_W-1:0] proc_wdata,
  output logic [1:0]          proc_done,
  output logic [2*DATA_W-1:0] proc_rdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);

  localparam int NPORT = 2;

  bus_phase_e        phase;
  logic              owner;
  logic [NPORT-1:0]  gnt_addr, gnt_resp, bus_req_v, bus_we_v;
  logic [ADDR_W-1:0] bus_addr_v  [NPORT];
  logic [DATA_W-1:0] bus_wdata_v [NPORT];

  wit_bus_arbiter #(.NPORT(NPORT)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req_v),
    .phase    (phase),
    .owner    (owner),
    .gnt_addr (gnt_addr),
    .gnt_resp (gnt_resp)
  );

  assign mem_en    = (phase == PH_ADDR);
  assign mem_we    = mem_en && bus_we_v[owner];
  assign mem_addr  = bus_addr_v[owner];
  assign mem_wdata = bus_wdata_v[owner];

  for (genvar g = 0; g < NPORT; g++) begin : g_cache
    logic snoop_wr;
    assign snoop_wr = mem_we && (owner != 1'(g));

    wit_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u_cache (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (proc_req[g]),
      .we         (proc_we[g]),
      .addr       (proc_addr[g*ADDR_W +: ADDR_W]),
      .wdata      (proc_wdata[g*DATA_W +: DATA_W]),
      .done       (proc_done[g]),
      .rdata      (proc_rdata[g*DATA_W +: DATA_W]),
      .bus_req    (bus_req_v[g]),
      .bus_we     (bus_we_v[g]),
      .bus_addr   (bus_addr_v[g]),
      .bus_wdata  (bus_wdata_v[g]),
      .gnt_addr   (gnt_addr[g]),
      .gnt_resp   (gnt_resp[g]),
      .mem_rdata  (mem_rdata),
      .snoop_wr   (snoop_wr),
      .snoop_addr (mem_addr)
    );
  end

  a_r7_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !mem_en);
  a_r9_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proc_done[0]) |-> $past(proc_req[0]));

endmodule

// File: tb/test_wit_coherent_pair.sv
module test_wit_coherent_pair;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] X = 8'h10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      proc_req = '0, proc_we = '0;
  logic [2*AW-1:0] proc_addr = '0;
  logic [2*DW-1:0] proc_wdata = '0;
  logic [1:0]      proc_done;
  logic [2*DW-1:0] proc_rdata;
  logic            mem_en, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata, mem_rdata;

  logic [DW-1:0] mem [256];
  int n_checks = 0, n_fail = 0, txn = 0, strobe_runs = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wit_coherent_pair #(.ADDR_W(AW), .DATA_W(DW), .SETS(4)) i_wit_coherent_pair (
    .clk(clk), .rst_n(rst_n), .proc_req(proc_req), .proc_we(proc_we),
    .proc_addr(proc_addr), .proc_wdata(proc_wdata), .proc_done(proc_done),
    .proc_rdata(proc_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  function automatic logic [DW-1:0] init_val(input int a);
    return (a == int'(X)) ? 16'd5 : 16'(a * 7 + 3);
  endfunction

  logic prev_en = 1'b0;
  always @(posedge clk) begin
    if (mem_en) begin
      txn <= txn + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
    if (rst_n && mem_en && prev_en) strobe_runs <= strobe_runs + 1;
    prev_en <= mem_en;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input int who, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd, output int cyc);
    @(negedge clk);
    proc_req[who] = 1'b1;
    proc_we[who] = we;
    proc_addr[who*AW +: AW] = a;
    proc_wdata[who*DW +: DW] = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!proc_done[who]);
    rd = proc_rdata[who*DW +: DW];
    proc_req[who] = 1'b0;
  endtask

  // read and check value, bus use and latency
  task automatic rd_chk(input int who, input logic [AW-1:0] a, input logic [DW-1:0] exp,
                        input bit expect_hit, input string req);
    logic [DW-1:0] v; int c; int t0;
    t0 = txn;
    access(who, 1'b0, a, '0, v, c);
    check(v == exp, req, v, exp);
    check((txn - t0) == (expect_hit ? 0 : 1), req, txn - t0, expect_hit ? 0 : 1);
    check(c == (expect_hit ? 1 : 4), req, c, expect_hit ? 1 : 4);
  endtask

  task automatic wr_chk(input int who, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string req);
    logic [DW-1:0] v; int c; int t0;
    t0 = txn;
    access(who, 1'b1, a, d, v, c);
    check((txn - t0) == 1, req, txn - t0, 1);
    check(mem[a] == d, req, mem[a], d);
  endtask

  task automatic t_reset();
    check(proc_done == 2'b00, "R9", proc_done, 0);
    check(mem_en == 1'b0, "R9", mem_en, 0);
  endtask

  // shared-block sequence on X, memory starts at 5
  task automatic t_sequence();
    rd_chk(0, X, 16'd5, 0, "R9 R2");
    rd_chk(1, X, 16'd5, 0, "R2");
    rd_chk(0, X, 16'd5, 1, "R5");
    rd_chk(1, X, 16'd5, 1, "R5 R1");
    wr_chk(1, X, 16'd7, "R3");
    rd_chk(1, X, 16'd7, 1, "R3 R1");
    wr_chk(1, X, 16'd9, "R3");
    wr_chk(0, X, 16'd11, "R3");
    rd_chk(0, X, 16'd11, 1, "R3");
    rd_chk(1, X, 16'd11, 0, "R4");
  endtask

  task automatic t_priority();
    logic [DW-1:0] v0, v1; int c0, c1;
    time d0, d1;
    fork
      begin access(0, 1'b0, 8'h21, '0, v0, c0); d0 = $time; end
      begin access(1, 1'b0, 8'h25, '0, v1, c1); d1 = $time; end
    join
    check(d0 < d1, "R6", int'(d0), int'(d1));
    check(v0 == init_val(8'h21), "R6", v0, init_val(8'h21));
    check(v1 == init_val(8'h25), "R6", v1, init_val(8'h25));
  endtask

  task automatic t_write_race();
    logic [DW-1:0] v0, v1; int c0, c1;
    rd_chk(0, 8'h32, init_val(8'h32), 0, "R2");
    rd_chk(1, 8'h32, init_val(8'h32), 0, "R2");
    fork
      access(0, 1'b1, 8'h32, 16'h00AA, v0, c0);
      access(1, 1'b1, 8'h32, 16'h00BB, v1, c1);
    join
    check(mem[8'h32] == 16'h00BB, "R6", mem[8'h32], 16'h00BB);
    rd_chk(0, 8'h32, 16'h00BB, 0, "R4");
    rd_chk(1, 8'h32, 16'h00BB, 1, "R4");
  endtask

  task automatic t_evict();
    rd_chk(0, 8'h04, init_val(8'h04), 0, "R8");
    rd_chk(0, 8'h08, init_val(8'h08), 0, "R8");
    rd_chk(0, 8'h04, init_val(8'h04), 0, "R8");
  endtask

  task automatic t_foreign_snoop();
    rd_chk(0, 8'h05, init_val(8'h05), 0, "R10");
    wr_chk(1, 8'h09, 16'h1234, "R10");
    rd_chk(0, 8'h05, init_val(8'h05), 1, "R10");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequence();
    t_priority();
    t_write_race();
    t_evict();
    t_foreign_snoop();
    check(strobe_runs == 0, "R7", strobe_runs, 0);
    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

endmodule